// File: doc/BRIEF.md
# Random Number Controller Register Interface

This block is the memory-mapped front end of a hardware random number generator. Software reaches it over a plain 32-bit register bus with one address, a write strobe, write data, a read strobe and combinational read data. Through five word registers it starts a self-test or a seeding run, masks the interrupt sources, watches progress and errors, and drains random words from a 16-deep output queue.

A timed stub stands in for the test and seeding machinery. Each run lasts a fixed number of cycles. Two test hooks make the next self-test fail, or make the next seeding run end with a statistical error. A Galois LFSR stands in for the entropy source. It refills the output queue one word per cycle, but only after a seeding run has finished without error.

One level interrupt covers two sources: a finished run and a recorded error. Each source has its own mask bit. Clearing a pending interrupt depends on the error state. A plain clear has no effect while an error is recorded. An error clear removes both the error code and the pending completion.

Top module: `rng_ctrl_regs`

## Requirements
- R1: After reset the control register reads 0x60 (both sources masked), the status and error registers read 0, and `irq` is low.
- R2: Control bits 5 (done mask) and 6 (error mask) are writable and read back; all other control bits read 0. The command register (0x04) always reads 0. Addresses other than 0x04, 0x08, 0x0C, 0x10 and 0x14 read 0.
- R3: Writing command bit 0 starts a self-test and clears status bit 4. Status bit 4 is set at the clock edge OP_CYCLES edges after the edge that accepted the write. If the failure hook is high at completion, error bit 0 (0x1) is set.
- R4: Writing command bit 1 starts a seeding run, clears status bit 5 and stops queue refill. Status bit 5 is set on completion. If the statistical hook is high at completion, error value 0x8 is recorded and refill stays off; otherwise refill resumes.
- R5: Status bits 11:8 report the queue level. A level of 16 shows as 0xF. The level counts down as words are read while refill is off.
- R6: Each read of 0x14 returns the oldest queued word and removes it. Words appear in LFSR order: the first word is 0x00000001, and each next word is (w >> 1) XOR 0x80200003 when bit 0 of w is set, otherwise w >> 1.
- R7: A read of 0x14 with an empty queue returns 0 and sets error bit 1 (0x2). Status bit 16 is 1 whenever the error register is nonzero.
- R8: `irq` = (completion pending AND control bit 5 = 0) OR (error register nonzero AND control bit 6 = 0).
- R9: Command bit 4 drops a pending completion only while the error register is 0. With an error recorded it changes nothing.
- R10: Command bit 5 zeroes the error register and drops a pending completion.
- R11: A start command written while a run is in progress is ignored. It neither restarts the timer nor changes the kind of run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe (queue pops on the edge) |
| bus_rdata | output | 32 | Read data, valid while bus_re is high |
| irq | output | 1 | Level interrupt |
| tst_fail_selftest | input | 1 | Test hook: next self-test completion reports failure |
| tst_fail_seed | input | 1 | Test hook: next seeding completion reports statistical error |

## Verification
The hardest state to reach is a draining queue whose level drops below full. Refill runs every cycle once seeding succeeds, so the queue refills as fast as it is read. The stimulus first fills the queue with a good seeding run. It then starts a second run with the statistical hook raised. This freezes refill and leaves 16 words to drain. Status readings at 13 and 0, and a final read from the empty queue, then show the level count-down and the underflow code combined with 0x8. Start commands are ignored during a run. The bench checks this by issuing a second self-test mid-run and sampling status one cycle before and exactly at the expected completion.

// File: rtl/rngc_pkg.sv
package rngc_pkg;

    localparam int DATA_W = 32;

    localparam logic [7:0] ADR_CMD  = 8'h04;
    localparam logic [7:0] ADR_CTRL = 8'h08;
    localparam logic [7:0] ADR_STAT = 8'h0C;
    localparam logic [7:0] ADR_ERR  = 8'h10;
    localparam logic [7:0] ADR_FIFO = 8'h14;

    localparam int CMD_SELFTEST = 0;
    localparam int CMD_SEED     = 1;
    localparam int CMD_CLR_INT  = 4;
    localparam int CMD_CLR_ERR  = 5;

    localparam int CTL_MASK_DONE = 5;
    localparam int CTL_MASK_ERR  = 6;

    localparam logic [DATA_W-1:0] ERR_SELFTEST  = 32'h1;
    localparam logic [DATA_W-1:0] ERR_UNDERFLOW = 32'h2;
    localparam logic [DATA_W-1:0] ERR_STAT      = 32'h8;

    typedef enum logic [1:0] {OP_NONE, OP_SELFTEST, OP_SEED} op_kind_e;

    typedef struct packed {
        logic              st_done_ev;
        logic              seed_done_ev;
        logic              seed_ok;
        logic [DATA_W-1:0] err_bits;
    } op_result_t;

    function automatic logic [DATA_W-1:0] lfsr_next(input logic [DATA_W-1:0] s,
                                                    input logic [DATA_W-1:0] poly);
        return (s >> 1) ^ (s[0] ? poly : '0);
    endfunction

endpackage

// File: rtl/rng_lfsr_src.sv
module rng_lfsr_src
    import rngc_pkg::*;
#(
    parameter logic [DATA_W-1:0] POLY = 32'h80200003,
    parameter logic [DATA_W-1:0] SEED = 32'h00000001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)      state_q <= SEED;
        else if (adv) state_q <= lfsr_next(state_q, POLY);
    end

    assign word = state_q;
endmodule

// File: rtl/rng_word_fifo.sv
module rng_word_fifo
    import rngc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [LW-1:0]     level,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [LW-1:0]     cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign full  = (int'(cnt_q) == DEPTH);
    assign empty = (cnt_q == '0);
    assign level = cnt_q;
    assign rdata = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/rng_op_engine.sv
module rng_op_engine
    import rngc_pkg::*;
#(
    parameter int OP_CYCLES = 8,
    localparam int CW = $clog2(OP_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_selftest,
    input  logic       req_seed,
    input  logic       fail_selftest,
    input  logic       fail_stat,
    output logic       busy,
    output logic       acc_selftest,
    output logic       acc_seed,
    output op_result_t res
);
    op_kind_e      kind_q;
    logic [CW-1:0] cnt_q;
    logic          fin;

    assign acc_selftest = !busy && req_selftest;
    assign acc_seed     = !busy && !req_selftest && req_seed;
    assign fin          = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            kind_q <= OP_NONE;
        end else if (!busy) begin
            if (acc_selftest || acc_seed) begin
                busy   <= 1'b1;
                cnt_q  <= CW'(OP_CYCLES - 1);
                kind_q <= acc_selftest ? OP_SELFTEST : OP_SEED;
            end
        end else if (fin) begin
            busy   <= 1'b0;
            kind_q <= OP_NONE;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        res              = '0;
        res.st_done_ev   = fin && (kind_q == OP_SELFTEST);
        res.seed_done_ev = fin && (kind_q == OP_SEED);
        res.seed_ok      = res.seed_done_ev && !fail_stat;
        if (res.st_done_ev && fail_selftest) res.err_bits = res.err_bits | ERR_SELFTEST;
        if (res.seed_done_ev && fail_stat)   res.err_bits = res.err_bits | ERR_STAT;
    end
endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
    import rngc_pkg::*;
#(
    parameter int                FIFO_DEPTH = 16,
    parameter int                OP_CYCLES  = 8,
    parameter logic [DATA_W-1:0] LFSR_POLY  = 32'h80200003,
    parameter logic [DATA_W-1:0] LFSR_SEED  = 32'h00000001,
    localparam int               LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              tst_fail_selftest,
    input  logic              tst_fail_seed
);
    logic              wr_cmd, wr_ctrl, rd_fifo;
    logic              clr_int, clr_err;
    logic              op_busy, acc_st, acc_seed;
    op_result_t        op_res;
    logic              mask_done, mask_err;
    logic              st_done_q, seed_done_q, done_pend, seeded_q;
    logic [DATA_W-1:0] err_q, rnd_word, head_word, stat_word;
    logic              push, pop, fifo_full, fifo_empty, underflow;
    logic [LVL_W-1:0]  fifo_level;
    logic [3:0]        lvl_disp;
    logic              unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata;

    assign wr_cmd  = bus_we && (bus_addr == ADR_CMD);
    assign wr_ctrl = bus_we && (bus_addr == ADR_CTRL);
    assign rd_fifo = bus_re && (bus_addr == ADR_FIFO);
    assign clr_int = wr_cmd && bus_wdata[CMD_CLR_INT];
    assign clr_err = wr_cmd && bus_wdata[CMD_CLR_ERR];

    rng_op_engine #(.OP_CYCLES(OP_CYCLES)) u_eng (
        .clk           (clk),
        .rst           (rst),
        .req_selftest  (wr_cmd && bus_wdata[CMD_SELFTEST]),
        .req_seed      (wr_cmd && bus_wdata[CMD_SEED]),
        .fail_selftest (tst_fail_selftest),
        .fail_stat     (tst_fail_seed),
        .busy          (op_busy),
        .acc_selftest  (acc_st),
        .acc_seed      (acc_seed),
        .res           (op_res)
    );

    assign push      = seeded_q && !fifo_full;
    assign pop       = rd_fifo && !fifo_empty;
    assign underflow = rd_fifo && fifo_empty;

    rng_lfsr_src #(.POLY(LFSR_POLY), .SEED(LFSR_SEED)) u_src (
        .clk  (clk),
        .rst  (rst),
        .adv  (push),
        .word (rnd_word)
    );

    rng_word_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .wdata (rnd_word),
        .pop   (pop),
        .rdata (head_word),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_done   <= 1'b1;
            mask_err    <= 1'b1;
            st_done_q   <= 1'b0;
            seed_done_q <= 1'b0;
            done_pend   <= 1'b0;
            seeded_q    <= 1'b0;
            err_q       <= '0;
        end else begin
            if (wr_ctrl) begin
                mask_done <= bus_wdata[CTL_MASK_DONE];
                mask_err  <= bus_wdata[CTL_MASK_ERR];
            end

            if (acc_st)                 st_done_q   <= 1'b0;
            else if (op_res.st_done_ev) st_done_q   <= 1'b1;
            if (acc_seed)                 seed_done_q <= 1'b0;
            else if (op_res.seed_done_ev) seed_done_q <= 1'b1;

            if (acc_seed)                seeded_q <= 1'b0;
            else if (op_res.seed_done_ev) seeded_q <= op_res.seed_ok;

            if (op_res.st_done_ev || op_res.seed_done_ev) done_pend <= 1'b1;
            else if (clr_err || (clr_int && err_q == '0)) done_pend <= 1'b0;

            err_q <= (clr_err ? '0 : err_q) | op_res.err_bits
                     | (underflow ? ERR_UNDERFLOW : '0);
        end
    end

    assign irq = (done_pend && !mask_done) || ((err_q != '0) && !mask_err);

    assign lvl_disp = (int'(fifo_level) > 15) ? 4'hF : 4'(fifo_level);

    always_comb begin
        stat_word       = '0;
        stat_word[4]    = st_done_q;
        stat_word[5]    = seed_done_q;
        stat_word[11:8] = lvl_disp;
        stat_word[16]   = (err_q != '0);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            unique case (bus_addr)
                ADR_CTRL: begin
                    bus_rdata[CTL_MASK_DONE] = mask_done;
                    bus_rdata[CTL_MASK_ERR]  = mask_err;
                end
                ADR_STAT: bus_rdata = stat_word;
                ADR_ERR:  bus_rdata = err_q;
                ADR_FIFO: bus_rdata = fifo_empty ? '0 : head_word;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rngc_checker.sv
module rngc_checker
    import rngc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic [LW-1:0]     fifo_level,
    input logic [DATA_W-1:0] err_q,
    input logic              done_pend,
    input logic              mask_done,
    input logic              mask_err,
    input logic              op_busy
);
    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == ADR_CMD) |-> (bus_rdata == '0)); // R2

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(fifo_level) <= DEPTH); // R5

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == ADR_FIFO && fifo_level == '0) |-> (bus_rdata == '0)); // R7

    AST_EMPTY_READ_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == ADR_FIFO && fifo_level == '0) |=> err_q[1]); // R7

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask_done && mask_err) |-> !irq); // R8

    AST_CLR_INT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (err_q != '0 && done_pend && !(bus_we && bus_addr == ADR_CMD && bus_wdata[CMD_CLR_ERR]))
        |=> done_pend); // R9

    AST_CLR_ERR_WIPES: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADR_CMD && bus_wdata[CMD_CLR_ERR] && !op_busy && !bus_re)
        |=> (err_q == '0 && !done_pend)); // R10
endmodule

bind rng_ctrl_regs rngc_checker #(.DEPTH(FIFO_DEPTH), .LW(LVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_re     (bus_re),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .fifo_level (fifo_level),
    .err_q      (err_q),
    .done_pend  (done_pend),
    .mask_done  (mask_done),
    .mask_err   (mask_err),
    .op_busy    (op_busy)
);

// File: tb/sim_rng_ctrl_regs.sv
`timescale 1ns/1ps
module sim_rng_ctrl_regs;
    localparam int OPC = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        tst_fail_selftest = 1'b0, tst_fail_seed = 1'b0;

    int n_chk = 0, n_bad = 0;
    logic [31:0] model_w = 32'h1;

    typedef struct { logic [31:0] data; string tag; } exp_t;
    exp_t expq[$];

    always #4 clk = ~clk;

    rng_ctrl_regs #(.OP_CYCLES(OPC)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .irq(irq), .tst_fail_selftest(tst_fail_selftest), .tst_fail_seed(tst_fail_seed)
    );

    // monitor: pops the scoreboard on each read, between drive and edge
    always @(negedge clk) begin
        #2;
        if (bus_re && expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            n_chk++;
            if (bus_rdata !== e.data) begin
                n_bad++;
                $display("FAIL %s: read 0x%08h expected 0x%08h", e.tag, bus_rdata, e.data);
            end
        end
    end

    // tasks are entered at a negedge and return at the next one
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_t x;
        x.data = e; x.tag = tag;
        expq.push_back(x);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic rd_word(input string tag);
        rd(8'h14, model_w, tag);
        model_w = (model_w >> 1) ^ (model_w[0] ? 32'h80200003 : 32'h0);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        n_chk++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq %0b expected %0b", tag, irq, e);
        end
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h08, 32'h60, "R1 ctrl");
        rd(8'h0C, 32'h0, "R1 status");
        rd(8'h10, 32'h0, "R1 error");
        chk_irq(1'b0, "R1 irq");

        // R2 register decode
        rd(8'h04, 32'h0, "R2 cmd");
        rd(8'h00, 32'h0, "R2 hole 0x00");
        rd(8'h18, 32'h0, "R2 hole 0x18");
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h60, "R2 ctrl all ones");
        wr(8'h08, 32'h20);
        rd(8'h08, 32'h20, "R2 ctrl done-mask only");

        // R7 empty read, R8/R9/R10 with error present
        rd(8'h14, 32'h0, "R7 empty read");
        rd(8'h0C, 32'h10000, "R7 status error bit");
        rd(8'h10, 32'h2, "R7 underflow code");
        chk_irq(1'b1, "R8 error source unmasked");
        wr(8'h04, 32'h10);
        chk_irq(1'b1, "R9 clear-int blocked");
        rd(8'h10, 32'h2, "R9 error kept");
        wr(8'h04, 32'h20);
        rd(8'h10, 32'h0, "R10 error wiped");
        chk_irq(1'b0, "R10 irq dropped");

        // R3 self-test pass with R11 ignored restart
        wr(8'h08, 32'h0);
        wr(8'h04, 32'h1);
        rd(8'h0C, 32'h0, "R3 running, done clear");
        @(negedge clk);
        wr(8'h04, 32'h1);
        repeat (OPC - 4) @(negedge clk);
        rd(8'h0C, 32'h0, "R11 one cycle before done");
        rd(8'h0C, 32'h10, "R11 done at original time");
        chk_irq(1'b1, "R8 done source unmasked");
        wr(8'h04, 32'h10);
        chk_irq(1'b0, "R9 clear-int without error");
        rd(8'h0C, 32'h10, "R3 done flag kept");

        // R3 self-test failure
        tst_fail_selftest = 1'b1;
        wr(8'h04, 32'h1);
        repeat (OPC + 2) @(negedge clk);
        rd(8'h0C, 32'h10010, "R3 fail status");
        rd(8'h10, 32'h1, "R3 fail code");
        chk_irq(1'b1, "R8 failing test");
        wr(8'h04, 32'h20);
        chk_irq(1'b0, "R10 clear after test fail");
        tst_fail_selftest = 1'b0;

        // R4 seeding with statistical error: no refill
        tst_fail_seed = 1'b1;
        wr(8'h04, 32'h2);
        repeat (OPC + 10) @(negedge clk);
        rd(8'h0C, 32'h10030, "R4 stat fail status, level 0");
        rd(8'h10, 32'h8, "R4 stat code");
        wr(8'h04, 32'h20);
        tst_fail_seed = 1'b0;

        // R4 good seed, R5 saturated level
        wr(8'h04, 32'h2);
        rd(8'h0C, 32'h10, "R4 seed done cleared at start");
        repeat (OPC + 20) @(negedge clk);
        rd(8'h0C, 32'hF30, "R5 full level shows 0xF");
        chk_irq(1'b1, "R8 seed completion");
        wr(8'h04, 32'h10);
        chk_irq(1'b0, "R9 clear after seed");

        // R6 ordered words while refill runs
        for (int i = 0; i < 20; i++) rd_word("R6 word order");
        repeat (30) @(negedge clk);
        rd(8'h0C, 32'hF30, "R5 refilled");

        // R4 failed reseed freezes refill, R5 count-down, R7 again
        wr(8'h08, 32'h60);
        tst_fail_seed = 1'b1;
        wr(8'h04, 32'h2);
        repeat (OPC + 4) @(negedge clk);
        chk_irq(1'b0, "R8 all masked with error");
        rd(8'h0C, 32'h10F30, "R4 frozen full");
        for (int i = 0; i < 3; i++) rd_word("R6 drain word");
        rd(8'h0C, 32'h10D30, "R5 level 13");
        for (int i = 0; i < 13; i++) rd_word("R6 drain word");
        rd(8'h0C, 32'h10030, "R5 level 0");
        rd(8'h14, 32'h0, "R7 empty after drain");
        rd(8'h10, 32'hA, "R7 underflow plus stat code");
        tst_fail_seed = 1'b0;

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule